// File: doc/BRIEF.md
# Indirect CSR Window Decoder

This block sits between a processor's indirect CSR access path and a per-source interrupt register bank. The processor supplies a select offset and a register index. The block turns each 32-bit access into many narrow operations on the bank. In the byte window, one word carries the same 8-bit field of four neighbouring sources. In the bit window, one word carries one flag from each of 32 neighbouring sources. A small range of offsets passes straight through to a set of 32-bit trigger words.

Reads gather from the bank state, which the bank presents as wide parallel vectors, and return one clock after the read strobe. Writes scatter into per-lane byte write strobes, per-source bit write masks and per-word trigger strobes. These all appear in the same cycle as the write strobe, so the bank commits them at that clock edge. A pending flag can only be written through the window for sources that the bank reports as edge-sensitive. Offsets and indices outside the defined windows read as zero and produce no write strobe.

Top module: `csr_window_decoder`

## Requirements
- R1: A read with select 0x000 to 0x3FF returns the control bytes of sources 4s..4s+3 for index 0, or their attribute bytes for index 1. Source 4s is placed in bits 7:0 and source 4s+3 in bits 31:24.
- R2: A read with select 0x400 to 0x47F returns, in bit b, the pending flag (index 0) or the enable flag (index 1) of source 32·(s−0x400)+b.
- R3: With index 0, select 0x480 to 0x49F reads trigger word s−0x480, which is zero if that word does not exist. A write there asserts only that word's strobe and passes the write data through. With index 1 this range is unhandled.
- R4: A select of 0x4A0 or above, an index above 1, or select 0x480 to 0x49F with index 1 reads as zero and produces no write strobe of any kind.
- R5: A byte-window write raises four byte strobes in the same cycle. Lane j targets byte address 4·(4s+j)+2 for index 0, or 4·(4s+j)+3 for index 1, and carries write data bits 8j+7:8j.
- R6: A bit-window write with index 1 raises the enable write mask for all 32 sources of the word, with data bit b going to source 32w+b. With index 0, the pending write mask is raised only for those sources whose edge flag is 1.
- R7: Sources numbered NUM_SRC or above read as zero in both windows, and their byte lanes and bit masks stay low on writes.
- R8: Read data and its valid flag update one clock after the read strobe. The valid flag lasts one cycle, the data holds until the next read, and both are zero after reset.
- R9: No write strobe is active in a cycle without the write strobe. At most one of the byte, bit and trigger strobe groups is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csrSel | input | SEL_W | Window select offset |
| csrIdx | input | IDX_W | Register index within the select |
| csrRd | input | 1 | Read strobe |
| csrWr | input | 1 | Write strobe |
| csrWdata | input | 32 | Write data |
| csrRdata | output | 32 | Read data, one clock after the read strobe |
| csrRvalid | output | 1 | Read data valid pulse |
| bankCtrl | input | NUM_SRC×8 | Control byte of each source |
| bankAttr | input | NUM_SRC×8 | Attribute byte of each source |
| bankPend | input | NUM_SRC | Pending flag of each source |
| bankEn | input | NUM_SRC | Enable flag of each source |
| bankEdge | input | NUM_SRC | Edge-sensitive flag of each source |
| trigWords | input | NUM_TRIG×32 | Trigger words |
| byteWrEn | output | 4 | Byte write strobe per lane |
| byteWrAddr | output | 4×BA_W | Byte address per lane |
| byteWrData | output | 32 | Byte lane data |
| pendWrEn | output | NUM_SRC | Pending write mask |
| enWrEn | output | NUM_SRC | Enable write mask |
| bitWrData | output | NUM_SRC | Bit write data per source |
| trigWrEn | output | NUM_TRIG | Trigger word write strobe |
| trigWrData | output | 32 | Trigger word write data |

## Verification
The hardest case to reach is the boundary where a window word only partly covers real sources, or lies wholly beyond them. The address is valid and the access looks normal, yet lanes or bits must drop out. The stimulus places the source count at the edge of a byte group and a bit word, then reads and writes the last populated group and the first empty one. The level protection is tested with an edge pattern that differs in every nibble, so a mask that ignores it or inverts it shows up at once in the pending write mask.

// File: rtl/csr_window_pkg.sv
package csr_window_pkg;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_BYTE = 2'd1,
    WIN_BIT  = 2'd2,
    WIN_TRIG = 2'd3
  } winRegion_e;

  typedef struct packed {
    winRegion_e region;
    logic       pickHi;
    logic       doRead;
    logic       doWrite;
  } winStrobe_t;

  localparam int unsigned BIT_BASE  = 32'h400;
  localparam int unsigned TRIG_BASE = 32'h480;
  localparam int unsigned RSVD_BASE = 32'h4A0;

endpackage

// File: rtl/csr_window_ctrl.sv
module csr_window_ctrl
  import csr_window_pkg::*;
#(
  parameter int SEL_W = 12,
  parameter int IDX_W = 3
) (
  input  logic [SEL_W-1:0] csrSel,
  input  logic [IDX_W-1:0] csrIdx,
  input  logic             csrRd,
  input  logic             csrWr,
  output winStrobe_t       strb
);

  logic idxOk;
  logic pickHi;
  winRegion_e region;

  assign idxOk  = (csrIdx <= IDX_W'(1));
  assign pickHi = (csrIdx == IDX_W'(1));

  always_comb begin
    region = WIN_NONE;
    if (idxOk) begin
      if (32'(csrSel) < BIT_BASE)       region = WIN_BYTE;
      else if (32'(csrSel) < TRIG_BASE) region = WIN_BIT;
      else if (32'(csrSel) < RSVD_BASE) region = pickHi ? WIN_NONE : WIN_TRIG;
      else                              region = WIN_NONE;
    end
  end

  always_comb begin
    strb.region  = region;
    strb.pickHi  = pickHi;
    strb.doRead  = csrRd;
    strb.doWrite = csrWr;
  end

endmodule

// File: rtl/csr_window_datapath.sv
module csr_window_datapath
  import csr_window_pkg::*;
#(
  parameter int SEL_W    = 12,
  parameter int NUM_SRC  = 64,
  parameter int NUM_TRIG = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  winStrobe_t                     strb,
  input  logic [SEL_W-1:0]               csrSel,
  input  logic [31:0]                    csrWdata,
  output logic [31:0]                    csrRdata,
  output logic                           csrRvalid,
  input  logic [NUM_SRC-1:0][7:0]        bankCtrl,
  input  logic [NUM_SRC-1:0][7:0]        bankAttr,
  input  logic [NUM_SRC-1:0]             bankPend,
  input  logic [NUM_SRC-1:0]             bankEn,
  input  logic [NUM_SRC-1:0]             bankEdge,
  input  logic [NUM_TRIG-1:0][31:0]      trigWords,
  output logic [3:0]                     byteWrEn,
  output logic [3:0][$clog2(NUM_SRC)+1:0] byteWrAddr,
  output logic [31:0]                    byteWrData,
  output logic [NUM_SRC-1:0]             pendWrEn,
  output logic [NUM_SRC-1:0]             enWrEn,
  output logic [NUM_SRC-1:0]             bitWrData,
  output logic [NUM_TRIG-1:0]            trigWrEn,
  output logic [31:0]                    trigWrData
);

  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int TG_W  = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic [9:0]  byteGroup;
  logic [6:0]  bitWord;
  logic [4:0]  trigIdx;
  logic        wrByte, wrBit, wrTrig;
  logic [31:0] byteGather, bitGather, trigGather, rdNext;

  assign byteGroup = csrSel[9:0];
  assign bitWord   = csrSel[6:0];
  assign trigIdx   = csrSel[4:0];

  assign wrByte = strb.doWrite && (strb.region == WIN_BYTE);
  assign wrBit  = strb.doWrite && (strb.region == WIN_BIT);
  assign wrTrig = strb.doWrite && (strb.region == WIN_TRIG);

  // byte window: one lane per neighbouring source
  for (genvar j = 0; j < 4; j++) begin : gLane
    logic [11:0]      srcFull;
    logic [SRC_W-1:0] srcIdx;
    logic             inRange;
    assign srcFull = {byteGroup, 2'(j)};
    assign srcIdx  = srcFull[SRC_W-1:0];
    assign inRange = (32'(srcFull) < NUM_SRC);
    assign byteGather[8*j +: 8] = !inRange ? 8'h00 :
                                  (strb.pickHi ? bankAttr[srcIdx] : bankCtrl[srcIdx]);
    assign byteWrEn[j]   = wrByte && inRange;
    assign byteWrAddr[j] = {srcIdx, 1'b1, strb.pickHi};
  end
  assign byteWrData = csrWdata;

  // bit window gather: one flag per source
  for (genvar b = 0; b < 32; b++) begin : gBitRd
    logic [11:0]      srcFull;
    logic [SRC_W-1:0] srcIdx;
    logic             inRange;
    assign srcFull = {bitWord, 5'(b)};
    assign srcIdx  = srcFull[SRC_W-1:0];
    assign inRange = (32'(srcFull) < NUM_SRC);
    assign bitGather[b] = inRange && (strb.pickHi ? bankEn[srcIdx] : bankPend[srcIdx]);
  end

  // bit window scatter: each source checks whether its word is addressed
  for (genvar i = 0; i < NUM_SRC; i++) begin : gBitWr
    logic hit;
    assign hit          = wrBit && (bitWord == 7'(i / 32));
    assign enWrEn[i]    = hit && strb.pickHi;
    assign pendWrEn[i]  = hit && !strb.pickHi && bankEdge[i];
    assign bitWrData[i] = csrWdata[i % 32];
  end

  // trigger words
  logic            trigInRange;
  logic [TG_W-1:0] trigSlot;
  assign trigInRange = (32'(trigIdx) < NUM_TRIG);
  assign trigSlot    = trigIdx[TG_W-1:0];
  assign trigGather  = trigInRange ? trigWords[trigSlot] : 32'h0;

  for (genvar t = 0; t < NUM_TRIG; t++) begin : gTrig
    assign trigWrEn[t] = wrTrig && (trigIdx == 5'(t));
  end
  assign trigWrData = csrWdata;

  always_comb begin
    unique case (strb.region)
      WIN_BYTE: rdNext = byteGather;
      WIN_BIT:  rdNext = bitGather;
      WIN_TRIG: rdNext = trigGather;
      default:  rdNext = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csrRdata  <= 32'h0;
      csrRvalid <= 1'b0;
    end else begin
      csrRvalid <= strb.doRead;
      if (strb.doRead) csrRdata <= rdNext;
    end
  end

endmodule

// File: rtl/csr_window_decoder.sv
module csr_window_decoder
  import csr_window_pkg::*;
#(
  parameter int SEL_W    = 12,
  parameter int IDX_W    = 3,
  parameter int NUM_SRC  = 64,
  parameter int NUM_TRIG = 4,
  localparam int BA_W    = $clog2(NUM_SRC) + 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [SEL_W-1:0]          csrSel,
  input  logic [IDX_W-1:0]          csrIdx,
  input  logic                      csrRd,
  input  logic                      csrWr,
  input  logic [31:0]               csrWdata,
  output logic [31:0]               csrRdata,
  output logic                      csrRvalid,
  input  logic [NUM_SRC-1:0][7:0]   bankCtrl,
  input  logic [NUM_SRC-1:0][7:0]   bankAttr,
  input  logic [NUM_SRC-1:0]        bankPend,
  input  logic [NUM_SRC-1:0]        bankEn,
  input  logic [NUM_SRC-1:0]        bankEdge,
  input  logic [NUM_TRIG-1:0][31:0] trigWords,
  output logic [3:0]                byteWrEn,
  output logic [3:0][BA_W-1:0]      byteWrAddr,
  output logic [31:0]               byteWrData,
  output logic [NUM_SRC-1:0]        pendWrEn,
  output logic [NUM_SRC-1:0]        enWrEn,
  output logic [NUM_SRC-1:0]        bitWrData,
  output logic [NUM_TRIG-1:0]       trigWrEn,
  output logic [31:0]               trigWrData
);

  winStrobe_t strb;

  csr_window_ctrl #(.SEL_W(SEL_W), .IDX_W(IDX_W)) u_ctrl (
    .csrSel (csrSel),
    .csrIdx (csrIdx),
    .csrRd  (csrRd),
    .csrWr  (csrWr),
    .strb   (strb)
  );

  csr_window_datapath #(.SEL_W(SEL_W), .NUM_SRC(NUM_SRC), .NUM_TRIG(NUM_TRIG)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .csrSel     (csrSel),
    .csrWdata   (csrWdata),
    .csrRdata   (csrRdata),
    .csrRvalid  (csrRvalid),
    .bankCtrl   (bankCtrl),
    .bankAttr   (bankAttr),
    .bankPend   (bankPend),
    .bankEn     (bankEn),
    .bankEdge   (bankEdge),
    .trigWords  (trigWords),
    .byteWrEn   (byteWrEn),
    .byteWrAddr (byteWrAddr),
    .byteWrData (byteWrData),
    .pendWrEn   (pendWrEn),
    .enWrEn     (enWrEn),
    .bitWrData  (bitWrData),
    .trigWrEn   (trigWrEn),
    .trigWrData (trigWrData)
  );

endmodule

// File: rtl/csr_window_decoder_chk.sv
module csr_window_decoder_chk #(
  parameter int SEL_W    = 12,
  parameter int IDX_W    = 3,
  parameter int NUM_SRC  = 64,
  parameter int NUM_TRIG = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [SEL_W-1:0]    csrSel,
  input logic [IDX_W-1:0]    csrIdx,
  input logic                csrRd,
  input logic                csrWr,
  input logic [31:0]         csrRdata,
  input logic                csrRvalid,
  input logic [NUM_SRC-1:0]  bankEdge,
  input logic [3:0]          byteWrEn,
  input logic [NUM_SRC-1:0]  pendWrEn,
  input logic [NUM_SRC-1:0]  enWrEn,
  input logic [NUM_TRIG-1:0] trigWrEn
);

  logic anyByte, anyBit, anyTrig;
  assign anyByte = |byteWrEn;
  assign anyBit  = |pendWrEn || |enWrEn;
  assign anyTrig = |trigWrEn;

  AST_WR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (anyByte || anyBit || anyTrig) |-> csrWr); // R9

  AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({anyByte, anyBit, anyTrig})); // R9

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    csrRd |=> csrRvalid); // R8

  AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    csrRvalid |-> $past(csrRd)); // R8

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (csrRd && (32'(csrSel) >= 32'h4A0)) |=> (csrRdata == 32'h0)); // R4

  AST_BAD_IDX_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (csrIdx > IDX_W'(1)) |-> !(anyByte || anyBit || anyTrig)); // R4

  AST_LEVEL_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    ((pendWrEn & ~bankEdge) == '0)); // R6

endmodule

bind csr_window_decoder csr_window_decoder_chk #(
  .SEL_W(SEL_W), .IDX_W(IDX_W), .NUM_SRC(NUM_SRC), .NUM_TRIG(NUM_TRIG)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csrSel    (csrSel),
  .csrIdx    (csrIdx),
  .csrRd     (csrRd),
  .csrWr     (csrWr),
  .csrRdata  (csrRdata),
  .csrRvalid (csrRvalid),
  .bankEdge  (bankEdge),
  .byteWrEn  (byteWrEn),
  .pendWrEn  (pendWrEn),
  .enWrEn    (enWrEn),
  .trigWrEn  (trigWrEn)
);

// File: tb/csr_window_decoder_bench.sv
`timescale 1ns/1ps
module csr_window_decoder_bench;

  localparam int NSRC  = 64;
  localparam int NTRIG = 4;
  localparam int BAW   = $clog2(NSRC) + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] csrSel = '0;
  logic [2:0]  csrIdx = '0;
  logic        csrRd = 1'b0, csrWr = 1'b0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata;
  logic        csrRvalid;
  logic [NSRC-1:0][7:0] bankCtrl, bankAttr;
  logic [NSRC-1:0] bankPend, bankEn, bankEdge;
  logic [NTRIG-1:0][31:0] trigWords;
  logic [3:0] byteWrEn;
  logic [3:0][BAW-1:0] byteWrAddr;
  logic [31:0] byteWrData, trigWrData;
  logic [NSRC-1:0] pendWrEn, enWrEn, bitWrData;
  logic [NTRIG-1:0] trigWrEn;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csr_window_decoder #(.NUM_SRC(NSRC), .NUM_TRIG(NTRIG)) u_csr_window_decoder (
    .clk(clk), .rstN(rstN), .csrSel(csrSel), .csrIdx(csrIdx), .csrRd(csrRd),
    .csrWr(csrWr), .csrWdata(csrWdata), .csrRdata(csrRdata), .csrRvalid(csrRvalid),
    .bankCtrl(bankCtrl), .bankAttr(bankAttr), .bankPend(bankPend), .bankEn(bankEn),
    .bankEdge(bankEdge), .trigWords(trigWords), .byteWrEn(byteWrEn),
    .byteWrAddr(byteWrAddr), .byteWrData(byteWrData), .pendWrEn(pendWrEn),
    .enWrEn(enWrEn), .bitWrData(bitWrData), .trigWrEn(trigWrEn), .trigWrData(trigWrData)
  );

  // {select, index, expected read data}
  localparam logic [46:0] VEC [16] = '{
    {12'h000, 3'd0, 32'h03020100},  // R1
    {12'h001, 3'd0, 32'h07060504},  // R1
    {12'h003, 3'd1, 32'h8F8E8D8C},  // R1
    {12'h00F, 3'd1, 32'hBFBEBDBC},  // R1
    {12'h010, 3'd0, 32'h00000000},  // R7
    {12'h3FF, 3'd1, 32'h00000000},  // R7
    {12'h400, 3'd0, 32'h12345678},  // R2
    {12'h401, 3'd0, 32'hDEADBEEF},  // R2
    {12'h400, 3'd1, 32'h0BADC0DE},  // R2
    {12'h401, 3'd1, 32'hCAFEF00D},  // R2
    {12'h402, 3'd1, 32'h00000000},  // R7
    {12'h480, 3'd0, 32'h70000000},  // R3
    {12'h483, 3'd0, 32'h70000003},  // R3
    {12'h480, 3'd1, 32'h00000000},  // R4
    {12'h4A0, 3'd0, 32'h00000000},  // R4
    {12'h000, 3'd2, 32'h00000000}   // R4
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [11:0] sel, input logic [2:0] idx,
                        input logic [31:0] exp, input string req);
    @(negedge clk);
    csrSel = sel; csrIdx = idx; csrRd = 1'b1;
    @(negedge clk);
    csrRd = 1'b0;
    check(64'(csrRdata), 64'(exp), req);
    check(64'(csrRvalid), 64'd1, "R8 valid pulse");
  endtask

  task automatic startWrite(input logic [11:0] sel, input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    csrSel = sel; csrIdx = idx; csrWdata = d; csrWr = 1'b1;
    #2;
  endtask

  task automatic endWrite();
    @(negedge clk);
    csrWr = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NSRC; i++) begin
      bankCtrl[i] = 8'(i);
      bankAttr[i] = 8'(8'h80 | 8'(i));
    end
    bankPend  = 64'hDEADBEEF_12345678;
    bankEn    = 64'hCAFEF00D_0BADC0DE;
    bankEdge  = 64'h00FF00FF_F0F0F0F0;
    for (int t = 0; t < NTRIG; t++) trigWords[t] = 32'h70000000 + 32'(t);

    repeat (3) @(negedge clk);
    check(64'(csrRdata), 64'd0, "R8 reset data");
    check(64'(csrRvalid), 64'd0, "R8 reset valid");
    rstN = 1'b1;
    @(negedge clk);
    check(64'(byteWrEn) | 64'(trigWrEn) | pendWrEn | enWrEn, 64'd0, "R9 idle strobes");

    for (int k = 0; k < 16; k++)
      doRead(VEC[k][46:35], VEC[k][34:32], VEC[k][31:0], "R1/R2/R3/R4/R7 table read");

    // R8: data holds, valid drops
    @(negedge clk);
    check(64'(csrRdata), 64'd0, "R8 hold data");
    check(64'(csrRvalid), 64'd0, "R8 valid drop");
    doRead(12'h401, 3'd0, 32'hDEADBEEF, "R2 read");
    @(negedge clk);
    check(64'(csrRdata), 64'hDEADBEEF, "R8 hold after read");

    // R5 byte writes
    startWrite(12'h002, 3'd0, 32'h44332211);
    check(64'(byteWrEn), 64'hF, "R5 lanes");
    check(64'(byteWrAddr[0]), 64'd34, "R5 lane0 addr");
    check(64'(byteWrAddr[3]), 64'd46, "R5 lane3 addr");
    check(64'(byteWrData), 64'h44332211, "R5 data");
    check(pendWrEn | enWrEn | 64'(trigWrEn), 64'd0, "R9 single group");
    endWrite();
    startWrite(12'h00F, 3'd1, 32'hA1B2C3D4);
    check(64'(byteWrAddr[0]), 64'd243, "R5 attr lane0 addr");
    check(64'(byteWrAddr[2]), 64'd251, "R5 attr lane2 addr");
    endWrite();
    startWrite(12'h010, 3'd0, 32'hFFFFFFFF);
    check(64'(byteWrEn), 64'd0, "R7 no lanes beyond sources");
    endWrite();

    // R6 bit writes
    startWrite(12'h401, 3'd1, 32'hFFFF0000);
    check(enWrEn, 64'hFFFFFFFF_00000000, "R6 enable mask");
    check(bitWrData[63:32], 64'hFFFF0000, "R6 enable data");
    check(pendWrEn, 64'd0, "R6 no pending");
    endWrite();
    startWrite(12'h400, 3'd0, 32'h0000FFFF);
    check(pendWrEn, 64'h00000000_F0F0F0F0, "R6 level protection");
    check(64'(bitWrData[31:0]), 64'h0000FFFF, "R6 pending data");
    endWrite();
    startWrite(12'h402, 3'd1, 32'hFFFFFFFF);
    check(enWrEn, 64'd0, "R7 no bits beyond sources");
    endWrite();

    // R3 trigger writes
    startWrite(12'h482, 3'd0, 32'h5555AAAA);
    check(64'(trigWrEn), 64'b0100, "R3 trigger strobe");
    check(64'(trigWrData), 64'h5555AAAA, "R3 trigger data");
    endWrite();

    // R4 unhandled writes
    startWrite(12'h480, 3'd1, 32'hFFFFFFFF);
    check(64'(byteWrEn) | 64'(trigWrEn) | pendWrEn | enWrEn, 64'd0, "R4 trig idx1");
    endWrite();
    startWrite(12'h4A0, 3'd0, 32'hFFFFFFFF);
    check(64'(byteWrEn) | 64'(trigWrEn) | pendWrEn | enWrEn, 64'd0, "R4 reserved");
    endWrite();
    startWrite(12'h001, 3'd3, 32'hFFFFFFFF);
    check(64'(byteWrEn) | 64'(trigWrEn) | pendWrEn | enWrEn, 64'd0, "R4 bad index");
    endWrite();
    #2;
    check(64'(byteWrEn) | 64'(trigWrEn) | pendWrEn | enWrEn, 64'd0, "R9 after write");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule